// File: doc/BRIEF.md
# I2C Addressed Slave Status Sequencer

This block is the byte-level engine of an I2C slave that a host processor controls. Start and stop conditions come in already detected, one clock wide. The block watches the sampled SCL and SDA lines and shifts in the address byte that follows a start condition. It compares the seven address bits with the upper seven bits of the host's own-address register. It answers with an acknowledge only while the host's acknowledge flag is set. After the address, it moves bytes between the bus and a one-byte data register, in either direction.

Each byte-level event loads a fixed status code and raises an interrupt flag. While the flag is set the block holds SCL low, and it holds it until the host has looked at the status, loaded or read the data register, and cleared the flag. The host ends its part in a transfer by clearing the acknowledge flag. A not-acknowledge, a deliberately unacknowledged byte or a stop condition returns the block to idle with status F8h and both lines released.

Top module: `i2c_slv_seq`

## Requirements
- R1: After reset, or on any cycle after the enable input is low, status is F8h, the interrupt flag is 0 and neither SCL nor SDA is driven. A matching address sent while disabled gets no acknowledge.
- R2: An address byte whose seven upper bits equal own_addr[7:1], with acknowledge flag set and R/W bit 0, is acknowledged (SDA driven low in the ninth clock). At the falling SCL edge after that clock, the interrupt flag rises with status 60h.
- R3: An address byte that does not match is not acknowledged, raises no interrupt and leaves status at F8h.
- R4: With the acknowledge flag clear, even a matching address is not acknowledged and raises no interrupt.
- R5: While the interrupt flag is set, SCL is driven low. The flag and the SCL hold both drop one cycle after the host pulses flag_clr.
- R6: In receive mode, a data byte (MSB first) is placed in the data register. With the acknowledge flag set it is acknowledged and reported with status 80h.
- R7: A data byte received with the acknowledge flag clear is not acknowledged and reports status 88h. Clearing the interrupt then returns the block to idle with status F8h.
- R8: A matching address with R/W bit 1 is acknowledged with status A8h. After the flag is cleared, the data register content is sent MSB first.
- R9: A sent byte answered with ACK, with the acknowledge flag set when the byte was loaded, reports B8h. A sent byte answered with NACK reports C0h, and clearing the interrupt after C0h returns to idle (F8h, SDA released).
- R10: A byte loaded while the acknowledge flag was clear and answered with ACK reports C8h. Clearing the interrupt then returns to idle with status F8h.
- R11: A stop condition ends any transfer: status F8h, interrupt flag 0, SCL and SDA released.
- R12: Bit 0 of own_addr takes no part in address matching.
- R13: A start condition seen while addressed restarts the address phase, so a new address byte is matched and answered.
- R14: SDA drive changes only while sampled SCL is low, except on start, stop or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Engine enable from host control |
| aa | input | 1 | Host acknowledge flag |
| flag_clr | input | 1 | One-cycle pulse: host clears the interrupt flag |
| own_addr | input | 8 | Own-address register; bits 7:1 hold the slave address |
| host_wr | input | 1 | Host write strobe to the data register |
| host_wdata | input | 8 | Host write data |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| start_det | input | 1 | Start (or repeated start) detected, one cycle |
| stop_det | input | 1 | Stop detected, one cycle |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| irq | output | 1 | Interrupt flag |
| status | output | 8 | Status code of the last byte-level event |
| data_q | output | 8 | Data register (received byte, or byte to send) |

## Verification
The hardest situations to reach are the transmit status codes C8h and C0h. Each needs a full read transfer first, and for C8h the acknowledge flag must be changed between the interrupt and its clear, because the block latches it when the byte is loaded. The bench models an open-drain bus whose lines are the AND of master and slave drives. Its master tasks wait for the stretched SCL to rise. Directed transfers then walk through A8h, B8h and C8h in one session and A8h and C0h in another, and read back every bit the slave drives. A repeated start and a stop arriving mid-byte are also driven on purpose.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

   localparam logic [7:0] ST_IDLE    = 8'hF8;
   localparam logic [7:0] ST_SW_ADR  = 8'h60;
   localparam logic [7:0] ST_SR_ACK  = 8'h80;
   localparam logic [7:0] ST_SR_NACK = 8'h88;
   localparam logic [7:0] ST_ST_ADR  = 8'hA8;
   localparam logic [7:0] ST_ST_ACK  = 8'hB8;
   localparam logic [7:0] ST_ST_NACK = 8'hC0;
   localparam logic [7:0] ST_ST_LAST = 8'hC8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_RX,
      S_ACKO,
      S_TX,
      S_ACKI,
      S_HOLD
   } seq_state_t;

endpackage

// File: rtl/i2c_slv_edge.sv
module i2c_slv_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic sda_s,
   output logic scl_s,
   output logic scl_rise,
   output logic scl_fall
);

   logic scl_d;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign scl_s = scl_raw;
         assign sda_s = sda_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_ff;
         logic [SYNC_STAGES-1:0] sda_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff[0] <= scl_raw;
               sda_ff[0] <= sda_raw;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  scl_ff[i] <= scl_ff[i-1];
                  sda_ff[i] <= sda_ff[i-1];
               end
            end
         end
         assign scl_s = scl_ff[SYNC_STAGES-1];
         assign sda_s = sda_ff[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_d <= 1'b1;
      else        scl_d <= scl_s;
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;

endmodule

// File: rtl/i2c_slv_shift.sv
module i2c_slv_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         shift,
   input  logic         bit_in,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= ld_val;
      else if (shift) q <= {q[W-2:0], bit_in};
   end

endmodule

// File: rtl/i2c_slv_seq.sv
module i2c_slv_seq
   import i2c_slv_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              aa,
   input  logic              flag_clr,
   input  logic [BYTE_W-1:0] own_addr,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              start_det,
   input  logic              stop_det,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              irq,
   output logic [7:0]        status,
   output logic [BYTE_W-1:0] data_q
);

   localparam int ADDR_W = BYTE_W - 1;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("i2c_slv_seq: BYTE_W must be 8");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("i2c_slv_seq: SYNC_STAGES must not be negative");
      end
   endgenerate

   seq_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic [7:0]        stat_q;
   logic [7:0]        pend_q;
   logic              irq_q, scl_q, sda_q, ack_drv_q, ack_in_q, last_q;
   logic [BYTE_W-1:0] dat_q;
   logic [BYTE_W-1:0] sh_q;
   logic              sda_s, scl_s, rise, fall;
   logic              go, sh_load, sh_shift, sh_bit, rx_done;
   logic              unused_own_lsb;

   assign unused_own_lsb = own_addr[0];

   i2c_slv_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
      .sda_s(sda_s), .scl_s(scl_s), .scl_rise(rise), .scl_fall(fall)
   );

   i2c_slv_shift #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .ld_val(dat_q),
      .shift(sh_shift), .bit_in(sh_bit), .q(sh_q)
   );

   always_comb begin
      go       = en && !stop_det && !(start_det && st != S_HOLD);
      sh_load  = go && st == S_HOLD && flag_clr &&
                 (stat_q == ST_ST_ADR || stat_q == ST_ST_ACK);
      sh_shift = 1'b0;
      sh_bit   = 1'b1;
      if (go && (st == S_ADDR || st == S_RX) && rise && cnt != CNT_FULL) begin
         sh_shift = 1'b1;
         sh_bit   = sda_s;
      end else if (go && st == S_TX && fall && cnt != CNT_FULL) begin
         sh_shift = 1'b1;
      end
      rx_done = go && st == S_RX && fall && cnt == CNT_FULL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dat_q <= '0;
      else if (rx_done)  dat_q <= sh_q;
      else if (host_wr)  dat_q <= host_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         cnt       <= '0;
         stat_q    <= ST_IDLE;
         pend_q    <= ST_IDLE;
         irq_q     <= 1'b0;
         scl_q     <= 1'b0;
         sda_q     <= 1'b0;
         ack_drv_q <= 1'b0;
         ack_in_q  <= 1'b0;
         last_q    <= 1'b0;
      end else if (!en || stop_det) begin
         st     <= S_IDLE;
         stat_q <= ST_IDLE;
         irq_q  <= 1'b0;
         scl_q  <= 1'b0;
         sda_q  <= 1'b0;
      end else if (start_det && st != S_HOLD) begin
         st    <= S_ADDR;
         cnt   <= '0;
         sda_q <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: ;
            S_ADDR, S_RX: begin
               if (rise && cnt != CNT_FULL) cnt <= cnt + 1'b1;
               if (fall && cnt == CNT_FULL) begin
                  cnt <= '0;
                  if (st == S_ADDR) begin
                     if (sh_q[BYTE_W-1:1] == own_addr[BYTE_W-1:BYTE_W-ADDR_W] && aa) begin
                        st        <= S_ACKO;
                        ack_drv_q <= 1'b1;
                        sda_q     <= 1'b1;
                        pend_q    <= sh_q[0] ? ST_ST_ADR : ST_SW_ADR;
                     end else begin
                        st <= S_IDLE;
                     end
                  end else begin
                     st        <= S_ACKO;
                     ack_drv_q <= aa;
                     sda_q     <= aa;
                     pend_q    <= aa ? ST_SR_ACK : ST_SR_NACK;
                  end
               end
            end
            S_ACKO: begin
               if (fall) begin
                  st     <= S_HOLD;
                  sda_q  <= 1'b0;
                  stat_q <= pend_q;
                  irq_q  <= 1'b1;
                  scl_q  <= 1'b1;
               end else begin
                  sda_q <= ack_drv_q;
               end
            end
            S_TX: begin
               if (rise && cnt != CNT_FULL) cnt <= cnt + 1'b1;
               if (fall) begin
                  if (cnt == CNT_FULL) begin
                     st    <= S_ACKI;
                     sda_q <= 1'b0;
                  end else begin
                     sda_q <= ~sh_q[BYTE_W-2];
                  end
               end
            end
            S_ACKI: begin
               if (rise) ack_in_q <= ~sda_s;
               if (fall) begin
                  st     <= S_HOLD;
                  irq_q  <= 1'b1;
                  scl_q  <= 1'b1;
                  stat_q <= !ack_in_q ? ST_ST_NACK : (last_q ? ST_ST_LAST : ST_ST_ACK);
               end
            end
            S_HOLD: begin
               if (flag_clr) begin
                  irq_q <= 1'b0;
                  scl_q <= 1'b0;
                  cnt   <= '0;
                  if (stat_q == ST_SW_ADR || stat_q == ST_SR_ACK) begin
                     st <= S_RX;
                  end else if (stat_q == ST_ST_ADR || stat_q == ST_ST_ACK) begin
                     st     <= S_TX;
                     sda_q  <= ~dat_q[BYTE_W-1];
                     last_q <= ~aa;
                  end else begin
                     st     <= S_IDLE;
                     stat_q <= ST_IDLE;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign scl_oe = scl_q;
   assign sda_oe = sda_q;
   assign irq    = irq_q;
   assign status = stat_q;
   assign data_q = dat_q;

endmodule

// File: rtl/i2c_slv_seq_chk.sv
module i2c_slv_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       flag_clr,
   input logic       scl_i,
   input logic       start_det,
   input logic       stop_det,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       irq,
   input logic [7:0] status
);

   // R1: disabling forces the idle state on the next cycle
   a_r1_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (status == 8'hF8 && !irq && !scl_oe && !sda_oe));

   // R2, R6..R10: a raised interrupt always carries a slave event code
   a_r2_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (status == 8'h60 || status == 8'h80 || status == 8'h88 ||
                      status == 8'hA8 || status == 8'hB8 || status == 8'hC0 ||
                      status == 8'hC8));

   // R5: the flag and the clock hold persist until the host clears them
   a_r5_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && en && !flag_clr && !stop_det) |=> (irq && scl_oe));

   // R11: a stop returns to idle with both lines released
   a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (status == 8'hF8 && !irq && !scl_oe && !sda_oe));

   // R14: SDA drive only moves in the low phase of SCL
   a_r14_sda_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && $past(en) && !$past(stop_det) && !$past(start_det))
         |-> !$past(scl_i));

endmodule

bind i2c_slv_seq i2c_slv_seq_chk u_i2c_slv_seq_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .flag_clr(flag_clr), .scl_i(scl_i),
   .start_det(start_det), .stop_det(stop_det), .scl_oe(scl_oe),
   .sda_oe(sda_oe), .irq(irq), .status(status)
);

// File: tb/test_i2c_slv_seq.sv
module test_i2c_slv_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, aa = 1'b0, flag_clr = 1'b0, host_wr = 1'b0;
   logic [7:0] own_addr = 8'h84, host_wdata = 8'h00;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic       start_det = 1'b0, stop_det = 1'b0;
   logic       scl_oe, sda_oe, irq;
   logic [7:0] status, data_q;
   logic       scl_line, sda_line;
   int         checks = 0, failures = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   assign scl_line = m_scl & ~scl_oe;
   assign sda_line = m_sda & ~sda_oe;

   i2c_slv_seq i_i2c_slv_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .aa(aa), .flag_clr(flag_clr),
      .own_addr(own_addr), .host_wr(host_wr), .host_wdata(host_wdata),
      .scl_i(scl_line), .sda_i(sda_line), .start_det(start_det),
      .stop_det(stop_det), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
      .status(status), .data_q(data_q)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      m_sda = b; tick(2);
      m_scl = 1'b1;
      while (!scl_line) tick(1);
      tick(4);
      m_scl = 1'b0; tick(2);
   endtask

   task automatic bit_in(output logic b);
      m_sda = 1'b1; tick(2);
      m_scl = 1'b1;
      while (!scl_line) tick(1);
      tick(2);
      b = sda_line;
      tick(2);
      m_scl = 1'b0; tick(2);
   endtask

   task automatic byte_out(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(b);
      acked = ~b;
   endtask

   task automatic byte_in(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         v[i] = b;
      end
      bit_out(~give_ack);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(1);
      m_scl = 1'b1; tick(2);
      m_sda = 1'b0; start_det = 1'b1; tick(1);
      start_det = 1'b0; tick(1);
      m_scl = 1'b0; tick(2);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(2);
      m_scl = 1'b1; tick(2);
      m_sda = 1'b1; stop_det = 1'b1; tick(1);
      stop_det = 1'b0; tick(2);
   endtask

   task automatic host_clear();
      flag_clr = 1'b1; tick(1);
      flag_clr = 1'b0; tick(1);
   endtask

   task automatic host_load(input logic [7:0] v);
      host_wr = 1'b1; host_wdata = v; tick(1);
      host_wr = 1'b0; tick(1);
   endtask

   task automatic t_reset_and_disabled();
      logic ack;
      chk("R1 reset status", status, 8'hF8);
      chk("R1 reset irq", irq, 0);
      chk("R1 reset line drive", {scl_oe, sda_oe}, 0);
      en = 1'b0; aa = 1'b1;
      bus_start();
      byte_out({7'h42, 1'b0}, ack);
      chk("R1 no ack while disabled", ack, 0);
      chk("R1 no irq while disabled", irq, 0);
      bus_stop();
      en = 1'b1;
   endtask

   task automatic t_mismatch();
      logic ack;
      aa = 1'b1; own_addr = 8'h84;
      bus_start();
      byte_out({7'h43, 1'b0}, ack);
      chk("R3 mismatch not acked", ack, 0);
      chk("R3 mismatch no irq", irq, 0);
      chk("R3 mismatch status", status, 8'hF8);
      bus_stop();
   endtask

   task automatic t_aa_clear_addr();
      logic ack;
      aa = 1'b0;
      bus_start();
      byte_out({7'h42, 1'b0}, ack);
      chk("R4 aa clear no ack", ack, 0);
      chk("R4 aa clear no irq", irq, 0);
      bus_stop();
      aa = 1'b1;
   endtask

   task automatic t_write();
      logic ack;
      aa = 1'b1;
      bus_start();
      byte_out({7'h42, 1'b0}, ack);
      chk("R2 address acked", ack, 1);
      chk("R2 irq raised", irq, 1);
      chk("R2 status 60h", status, 8'h60);
      chk("R5 scl held while flagged", scl_oe, 1);
      tick(6);
      chk("R5 scl still held", scl_oe, 1);
      host_clear();
      chk("R5 scl released after clear", {scl_oe, irq}, 0);
      byte_out(8'hA5, ack);
      chk("R6 data acked", ack, 1);
      chk("R6 status 80h", status, 8'h80);
      chk("R6 data register", data_q, 8'hA5);
      aa = 1'b0;
      host_clear();
      byte_out(8'h3C, ack);
      chk("R7 data not acked", ack, 0);
      chk("R7 status 88h", status, 8'h88);
      chk("R7 data register", data_q, 8'h3C);
      host_clear();
      chk("R7 idle after clear", status, 8'hF8);
      bus_stop();
      aa = 1'b1;
   endtask

   task automatic t_read_last();
      logic ack;
      logic [7:0] v;
      aa = 1'b1; own_addr = 8'h85;
      bus_start();
      byte_out({7'h42, 1'b1}, ack);
      chk("R12 own_addr bit0 ignored", ack, 1);
      chk("R8 status A8h", status, 8'hA8);
      host_load(8'hC3);
      host_clear();
      byte_in(v, 1'b1);
      chk("R8 byte sent MSB first", v, 8'hC3);
      chk("R9 status B8h", status, 8'hB8);
      host_load(8'h5A);
      aa = 1'b0;
      host_clear();
      aa = 1'b1;
      byte_in(v, 1'b1);
      chk("R10 last byte value", v, 8'h5A);
      chk("R10 status C8h", status, 8'hC8);
      host_clear();
      chk("R10 idle after clear", status, 8'hF8);
      bus_stop();
      own_addr = 8'h84;
   endtask

   task automatic t_read_nack();
      logic ack;
      logic [7:0] v;
      aa = 1'b1;
      bus_start();
      byte_out({7'h42, 1'b1}, ack);
      chk("R8 read address acked", ack, 1);
      host_load(8'h81);
      host_clear();
      byte_in(v, 1'b0);
      chk("R8 second byte", v, 8'h81);
      chk("R9 status C0h", status, 8'hC0);
      host_clear();
      chk("R9 idle after C0h", status, 8'hF8);
      chk("R9 sda released", sda_oe, 0);
      bus_stop();
   endtask

   task automatic t_stop_mid_byte();
      logic ack;
      aa = 1'b1;
      bus_start();
      byte_out({7'h42, 1'b0}, ack);
      host_clear();
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      chk("R11 still addressed", status, 8'h60);
      bus_stop();
      chk("R11 stop gives F8h", status, 8'hF8);
      chk("R11 lines released", {irq, scl_oe, sda_oe}, 0);
   endtask

   task automatic t_repeated_start();
      logic ack;
      aa = 1'b1;
      bus_start();
      byte_out({7'h42, 1'b0}, ack);
      host_clear();
      bit_out(1'b0); bit_out(1'b1);
      bus_start();
      byte_out({7'h42, 1'b1}, ack);
      chk("R13 new address acked", ack, 1);
      chk("R13 status A8h", status, 8'hA8);
      host_load(8'hFF);
      host_clear();
      bus_stop();
      chk("R13 idle after stop", status, 8'hF8);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset_and_disabled();
      t_mismatch();
      t_aa_clear_addr();
      t_write();
      t_read_last();
      t_read_nack();
      t_stop_mid_byte();
      t_repeated_start();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule